// File: doc/BRIEF.md
# Register Window Call/Return Controller

This block tracks a rotating window of registers that slides over a physical register file of `NUM_AREGS` entries. The file is treated as `NUM_AREGS/4` groups of four. The block holds two pieces of state. The first is the current window base, a group index. The second is a bitmap with one bit per group, marking the groups where a live call frame begins. A decode stage issues one of three commands to it: a call entry carrying a rotation increment of 0 to 3 groups, a windowed return, or a stack-allocation check. The block decides in a single cycle whether the command completes, is illegal, or must first spill or refill frames held in memory.

Moving register contents and running the spill/fill handlers belong to the surrounding core. This block only moves the base pointer, edits the frame bitmap and reports results. Those results are a one-cycle done pulse, one fault code, the return target, the faulting instruction address, the base value in force before a spill or refill, and a pulse that tells the core to enter exception mode.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window base is 0, only frame bit 0 is set, `done_o` is low and `fault_o` is 0 (none).
- R2: An entry command (`cmd_op_i`=1) is illegal, `fault_o`=1, when `sp_sel_i` exceeds 3 or when the status inputs are not `woe_i`=1 with `excm_i`=0. An illegal entry leaves the base and the bitmap unchanged.
- R3: A legal entry whose check finds no live frame completes with `fault_o`=0. It advances the base by `callinc_i` modulo `NUM_AREGS/4` and sets the frame bit of the new base. No other bit changes.
- R4: Let the bitmap be viewed from base+1 upward, with wrap. A legal entry overflows when any of its lowest `callinc_i` positions is set. The base then advances by (index of the first set position)+1, and the bitmap is unchanged. The fault code depends on the gap from that point to the next set position: a gap of 0 gives 2 (spill 4), a gap of 1 gives 3 (spill 8), and any larger gap gives 4 (spill 12).
- R5: Every fault loads `exc_pc_o` with `pc_i` and pulses `excm_set_o`. On an overflow or underflow, `owb_o` is also loaded with the base as it stood before the command.
- R6: A return command (`cmd_op_i`=2) takes its size n from bits 31:30 of `link_i`. Let m be 1, 2 or 3 for the nearest set frame bit at base-1, base-2 or base-3, or 0 if none of them is set. The return is illegal (`fault_o`=1, base and bitmap unchanged) when n is 0, when m is nonzero and differs from n, or when the status condition of R2 fails.
- R7: A legal return sets `ret_pc_o` to bits 31:30 of `pc_i` joined with bits 29:0 of `link_i`, and moves the base back by n. If the frame bit of the new base is set, it clears the frame bit of the old base and reports `fault_o`=0.
- R8: If the new base's frame bit is clear on a legal return, the block reports underflow: code 5, 6 or 7 for n = 1, 2 or 3. The base still moves back by n, and the bitmap is unchanged.
- R9: The alloca command (`cmd_op_i`=3) reports `fault_o`=8 when none of the frame bits at base-1, base-2 and base-3 is set, and 0 otherwise. It never changes the base or the bitmap.
- R10: Every non-idle command yields exactly one `done_o` pulse in the next cycle, with its code on `fault_o`. An idle cycle (`cmd_op_i`=0) leaves `done_o` low and the base and bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op_i | input | 2 | 0 idle, 1 entry, 2 return, 3 alloca check |
| callinc_i | input | 2 | Rotation increment (groups) for an entry |
| sp_sel_i | input | 4 | Stack register selector of an entry |
| woe_i | input | 1 | Window overflow enable status bit |
| excm_i | input | 1 | Exception mode status bit |
| pc_i | input | PC_W | Address of the issuing instruction |
| link_i | input | PC_W | Contents of register 0 (return size and target) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 4 | Result code, valid with done_o |
| win_base_o | output | clog2(NUM_AREGS/4) | Current window base |
| win_start_o | output | NUM_AREGS/4 | Frame-start bitmap |
| ret_pc_o | output | PC_W | Return target of the last non-illegal return |
| exc_pc_o | output | PC_W | Instruction address of the last fault |
| owb_o | output | clog2(NUM_AREGS/4) | Base saved by the last overflow or underflow |
| excm_set_o | output | 1 | Pulse requesting exception mode, with done_o on a fault |

## Verification
The embedded properties assume that the command inputs are held idle while reset is asserted, so their history at the first active edge is meaningful. They also assume the bitmap is reachable only through commands, which makes it never empty. The stimulus leaves reset with the command idle and starts with directed sequences. These build frames up to an overflow, return into live and missing frames, and hit every illegal condition. Random commands follow, kept within the 2-bit return sizes, with occasional resets. A behavioural model with plain integers predicts the state and checks every output each cycle.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_ENTRY  = 2'd1,
      OP_RETW   = 2'd2,
      OP_ALLOCA = 2'd3
   } rw_op_e;

   typedef enum logic [3:0] {
      FLT_NONE    = 4'd0,
      FLT_ILLEGAL = 4'd1,
      FLT_OVF4    = 4'd2,
      FLT_OVF8    = 4'd3,
      FLT_OVF12   = 4'd4,
      FLT_UNF4    = 4'd5,
      FLT_UNF8    = 4'd6,
      FLT_UNF12   = 4'd7,
      FLT_ALLOCA  = 4'd8
   } rw_fault_e;

endpackage

// File: rtl/regwin_scan.sv
// Views the frame bitmap relative to the current base: upward from base+1
// (wrapping) and the three groups just below the base.
module regwin_scan #(
   parameter int NGRP = 16,
   parameter int BW   = 4
) (
   input  logic [BW-1:0]   base_i,
   input  logic [NGRP-1:0] start_i,
   output logic [NGRP-1:0] above_o,
   output logic [2:0]      below_o
);

   for (genvar i = 0; i < NGRP; i++) begin : g_up
      logic [BW-1:0] idx;
      assign idx        = base_i + BW'(i + 1);
      assign above_o[i] = start_i[idx];
   end

   for (genvar j = 0; j < 3; j++) begin : g_dn
      logic [BW-1:0] idx;
      assign idx        = base_i - BW'(j + 1);
      assign below_o[j] = start_i[idx];
   end

endmodule

// File: rtl/regwin_tz.sv
// Trailing-zero counter; an all-zero vector yields W.
module regwin_tz #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   always_comb begin
      cnt_o = CW'(W);
      for (int k = W - 1; k >= 0; k--) begin
         if (vec_i[k]) cnt_o = CW'(k);
      end
   end

endmodule

// File: rtl/regwin_eval.sv
// Combinational command evaluation: next base, next bitmap and result code.
module regwin_eval
   import regwin_pkg::*;
#(
   parameter int NGRP = 16,
   parameter int BW   = 4,
   parameter int CW   = 5
) (
   input  rw_op_e          op_i,
   input  logic [1:0]      callinc_i,
   input  logic [3:0]      sel_i,
   input  logic            woe_i,
   input  logic            excm_i,
   input  logic [1:0]      ret_n_i,
   input  logic [BW-1:0]   base_i,
   input  logic [NGRP-1:0] start_i,
   input  logic [NGRP-1:0] above_i,
   input  logic [2:0]      below_i,
   input  logic [CW-1:0]   tz_first_i,
   input  logic [CW-1:0]   tz_next_i,
   output logic [BW-1:0]   nxt_base_o,
   output logic [NGRP-1:0] nxt_start_o,
   output rw_fault_e       fault_o,
   output logic            save_owb_o,
   output logic            ret_ok_o
);

   logic          status_ok;
   logic [2:0]    ci_mask;
   logic [1:0]    live_m;
   logic [CW-1:0] spill_n;
   logic [BW-1:0] ent_base;
   logic [BW-1:0] ret_base;

   assign status_ok = woe_i & ~excm_i;
   assign ci_mask   = {callinc_i == 2'd3, callinc_i >= 2'd2, callinc_i != 2'd0};
   assign live_m    = below_i[0] ? 2'd1 : below_i[1] ? 2'd2 : below_i[2] ? 2'd3 : 2'd0;
   assign spill_n   = tz_first_i + CW'(1);
   assign ent_base  = base_i + BW'(callinc_i);
   assign ret_base  = base_i - BW'(ret_n_i);

   always_comb begin
      nxt_base_o  = base_i;
      nxt_start_o = start_i;
      fault_o     = FLT_NONE;
      save_owb_o  = 1'b0;
      ret_ok_o    = 1'b0;
      unique case (op_i)
         OP_ENTRY: begin
            if (sel_i > 4'd3 || !status_ok) begin
               fault_o = FLT_ILLEGAL;
            end else if (|(above_i[2:0] & ci_mask)) begin
               save_owb_o = 1'b1;
               nxt_base_o = base_i + BW'(spill_n);
               if (tz_next_i == CW'(0))      fault_o = FLT_OVF4;
               else if (tz_next_i == CW'(1)) fault_o = FLT_OVF8;
               else                          fault_o = FLT_OVF12;
            end else begin
               nxt_base_o  = ent_base;
               nxt_start_o = start_i | (NGRP'(1) << ent_base);
            end
         end
         OP_RETW: begin
            if (ret_n_i == 2'd0 || (live_m != 2'd0 && live_m != ret_n_i) || !status_ok) begin
               fault_o = FLT_ILLEGAL;
            end else begin
               ret_ok_o   = 1'b1;
               nxt_base_o = ret_base;
               if (start_i[ret_base]) begin
                  nxt_start_o = start_i & ~(NGRP'(1) << base_i);
               end else begin
                  save_owb_o = 1'b1;
                  unique case (ret_n_i)
                     2'd1:    fault_o = FLT_UNF4;
                     2'd2:    fault_o = FLT_UNF8;
                     default: fault_o = FLT_UNF12;
                  endcase
               end
            end
         end
         OP_ALLOCA: begin
            if (below_i == 3'b000) fault_o = FLT_ALLOCA;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int NUM_AREGS = 64,
   parameter int PC_W      = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [1:0]                       cmd_op_i,
   input  logic [1:0]                       callinc_i,
   input  logic [3:0]                       sp_sel_i,
   input  logic                             woe_i,
   input  logic                             excm_i,
   input  logic [PC_W-1:0]                  pc_i,
   input  logic [PC_W-1:0]                  link_i,
   output logic                             done_o,
   output logic [3:0]                       fault_o,
   output logic [$clog2(NUM_AREGS/4)-1:0]   win_base_o,
   output logic [NUM_AREGS/4-1:0]           win_start_o,
   output logic [PC_W-1:0]                  ret_pc_o,
   output logic [PC_W-1:0]                  exc_pc_o,
   output logic [$clog2(NUM_AREGS/4)-1:0]   owb_o,
   output logic                             excm_set_o
);

   localparam int NGRP = NUM_AREGS / 4;
   localparam int BW   = $clog2(NGRP);
   localparam int CW   = $clog2(NGRP + 1);

   if (NUM_AREGS % 4 != 0 || NGRP < 4 || (NGRP & (NGRP - 1)) != 0) begin : g_bad_nareg
      $error("regwin_ctrl: NUM_AREGS must be four times a power of two, at least 16");
   end
   if (PC_W < 4) begin : g_bad_pcw
      $error("regwin_ctrl: PC_W too small");
   end

   rw_op_e          op;
   logic [BW-1:0]   base_q;
   logic [NGRP-1:0] start_q;
   logic [NGRP-1:0] above;
   logic [2:0]      below;
   logic [CW-1:0]   tz_first;
   logic [CW-1:0]   tz_next;
   logic [NGRP-1:0] above_shift;
   logic [BW-1:0]   nxt_base;
   logic [NGRP-1:0] nxt_start;
   rw_fault_e       nxt_fault;
   logic            save_owb;
   logic            ret_ok;

   assign op          = rw_op_e'(cmd_op_i);
   assign above_shift = above >> (tz_first + CW'(1));

   regwin_scan #(.NGRP(NGRP), .BW(BW)) u_scan (
      .base_i  (base_q),
      .start_i (start_q),
      .above_o (above),
      .below_o (below)
   );

   regwin_tz #(.W(NGRP), .CW(CW)) u_tz_first (
      .vec_i (above),
      .cnt_o (tz_first)
   );

   regwin_tz #(.W(NGRP), .CW(CW)) u_tz_next (
      .vec_i (above_shift),
      .cnt_o (tz_next)
   );

   regwin_eval #(.NGRP(NGRP), .BW(BW), .CW(CW)) u_eval (
      .op_i        (op),
      .callinc_i   (callinc_i),
      .sel_i       (sp_sel_i),
      .woe_i       (woe_i),
      .excm_i      (excm_i),
      .ret_n_i     (link_i[PC_W-1:PC_W-2]),
      .base_i      (base_q),
      .start_i     (start_q),
      .above_i     (above),
      .below_i     (below),
      .tz_first_i  (tz_first),
      .tz_next_i   (tz_next),
      .nxt_base_o  (nxt_base),
      .nxt_start_o (nxt_start),
      .fault_o     (nxt_fault),
      .save_owb_o  (save_owb),
      .ret_ok_o    (ret_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q     <= '0;
         start_q    <= NGRP'(1);
         done_o     <= 1'b0;
         fault_o    <= FLT_NONE;
         ret_pc_o   <= '0;
         exc_pc_o   <= '0;
         owb_o      <= '0;
         excm_set_o <= 1'b0;
      end else begin
         base_q     <= nxt_base;
         start_q    <= nxt_start;
         done_o     <= (op != OP_IDLE);
         fault_o    <= nxt_fault;
         excm_set_o <= (nxt_fault != FLT_NONE);
         if (nxt_fault != FLT_NONE) exc_pc_o <= pc_i;
         if (save_owb)              owb_o    <= base_q;
         if (ret_ok)                ret_pc_o <= {pc_i[PC_W-1:PC_W-2], link_i[PC_W-3:0]};
      end
   end

   assign win_base_o  = base_q;
   assign win_start_o = start_q;

   // R10: idle cycle changes nothing and raises no done
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_i == OP_IDLE |=> !done_o && $stable(win_base_o) && $stable(win_start_o));

   // R2 / R6: illegal commands leave window state untouched
   p_illegal_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FLT_ILLEGAL |-> $stable(win_base_o) && $stable(win_start_o));

   // R3: completed entry marks the frame at the new base
   p_entry_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FLT_NONE && $past(cmd_op_i) == OP_ENTRY |-> win_start_o[win_base_o]);

   // R5: spill/refill faults save the previous base and request exception mode
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o >= FLT_OVF4 && fault_o <= FLT_UNF12
      |-> excm_set_o && owb_o == $past(win_base_o));

   // R8: an underflow leaves the bitmap as it was
   p_underflow_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o >= FLT_UNF4 && fault_o <= FLT_UNF12 |-> $stable(win_start_o));

   // R7: bitmap never becomes empty, return target keeps the PC region
   p_start_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_start_o != '0);
   p_ret_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FLT_NONE && $past(cmd_op_i) == OP_RETW
      |-> ret_pc_o[PC_W-1:PC_W-2] == $past(pc_i[PC_W-1:PC_W-2]));

   // R9: alloca check never moves the window
   p_alloca_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op_i == OP_ALLOCA |=> $stable(win_base_o) && $stable(win_start_o));

endmodule

// File: tb/regwin_ctrl_tb.sv
module regwin_ctrl_tb;

   localparam int NUM_AREGS = 64;
   localparam int PC_W      = 32;
   localparam int G         = NUM_AREGS / 4;
   localparam int BW        = $clog2(G);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      cmd_op = 2'd0;
   logic [1:0]      callinc = 2'd0;
   logic [3:0]      sp_sel = 4'd0;
   logic            woe = 1'b1;
   logic            excm = 1'b0;
   logic [PC_W-1:0] pc = '0;
   logic [PC_W-1:0] link = '0;
   logic            done;
   logic [3:0]      fault;
   logic [BW-1:0]   win_base;
   logic [G-1:0]    win_start;
   logic [PC_W-1:0] ret_pc;
   logic [PC_W-1:0] exc_pc;
   logic [BW-1:0]   owb;
   logic            excm_set;

   always #4 clk = ~clk;

   regwin_ctrl #(.NUM_AREGS(NUM_AREGS), .PC_W(PC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_op_i(cmd_op), .callinc_i(callinc),
      .sp_sel_i(sp_sel), .woe_i(woe), .excm_i(excm), .pc_i(pc), .link_i(link),
      .done_o(done), .fault_o(fault), .win_base_o(win_base), .win_start_o(win_start),
      .ret_pc_o(ret_pc), .exc_pc_o(exc_pc), .owb_o(owb), .excm_set_o(excm_set)
   );

   int checks = 0;
   int errors = 0;

   // behavioural model state
   int    m_base;
   bit    m_ws [G];
   int    e_fault;
   bit    e_done;
   bit    chk_exc, chk_owb, chk_ret;
   int    e_owb;
   longint e_exc_pc, e_ret_pc;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic longint ws_vec();
      longint v = 0;
      for (int i = 0; i < G; i++) if (m_ws[i]) v |= (64'd1 << i);
      return v;
   endfunction

   task automatic model_reset();
      m_base = 0;
      for (int i = 0; i < G; i++) m_ws[i] = 0;
      m_ws[0] = 1;
      e_fault = 0; e_done = 0;
      chk_exc = 0; chk_owb = 0; chk_ret = 0;
      cur_req = "R1";
   endtask

   task automatic check_outputs();
      chk(done == e_done, "R10", "done", done, e_done);
      chk(fault == e_fault[3:0], cur_req, "fault", fault, e_fault);
      chk(win_base == BW'(m_base), cur_req, "base", win_base, m_base);
      chk(win_start == G'(ws_vec()), cur_req, "start", win_start, ws_vec());
      if (chk_exc) begin
         chk(exc_pc == PC_W'(e_exc_pc), "R5", "exc_pc", exc_pc, e_exc_pc);
         chk(excm_set == 1'b1, "R5", "excm_set", excm_set, 1);
      end else begin
         chk(excm_set == 1'b0, "R5", "excm_set", excm_set, 0);
      end
      if (chk_owb) chk(owb == BW'(e_owb), "R5", "owb", owb, e_owb);
      if (chk_ret) chk(ret_pc == PC_W'(e_ret_pc), "R7", "ret_pc", ret_pc, e_ret_pc);
   endtask

   function automatic bit wsr(input int p);
      return m_ws[((p % G) + G) % G];
   endfunction

   task automatic model_apply(input int op, input int ci, input int sel, input bit w,
                              input bit x, input longint p, input longint l);
      bit ok_stat = w && !x;
      e_done = (op != 0);
      e_fault = 0; chk_exc = 0; chk_owb = 0; chk_ret = 0;
      cur_req = "R10";
      if (op == 1) begin
         if (sel > 3 || !ok_stat) begin
            e_fault = 1; cur_req = "R2";
         end else begin
            int first = -1;
            for (int i = 0; i < ci; i++) if (first < 0 && wsr(m_base + 1 + i)) first = i;
            if (first >= 0) begin
               int n = first + 1;
               int gap = 99;
               for (int j = n; j < G; j++) if (gap == 99 && wsr(m_base + 1 + j)) gap = j - n;
               e_fault = (gap == 0) ? 2 : (gap == 1) ? 3 : 4;
               e_owb = m_base; chk_owb = 1;
               m_base = (m_base + n) % G;
               cur_req = "R4";
            end else begin
               m_base = (m_base + ci) % G;
               m_ws[m_base] = 1;
               cur_req = "R3";
            end
         end
      end else if (op == 2) begin
         int n = int'(l >> 30) & 3;
         int m = wsr(m_base - 1) ? 1 : wsr(m_base - 2) ? 2 : wsr(m_base - 3) ? 3 : 0;
         if (n == 0 || (m != 0 && m != n) || !ok_stat) begin
            e_fault = 1; cur_req = "R6";
         end else begin
            int nb = (m_base - n + G) % G;
            e_ret_pc = (p & 64'hC000_0000) | (l & 64'h3FFF_FFFF);
            if (m_ws[nb]) begin
               m_ws[m_base] = 0;
               chk_ret = 1;
               cur_req = "R7";
            end else begin
               e_fault = 4 + n;
               e_owb = m_base; chk_owb = 1;
               cur_req = "R8";
            end
            m_base = nb;
         end
      end else if (op == 3) begin
         cur_req = "R9";
         if (!wsr(m_base - 1) && !wsr(m_base - 2) && !wsr(m_base - 3)) e_fault = 8;
      end
      if (e_fault != 0) begin
         chk_exc = 1; e_exc_pc = p;
      end
   endtask

   task automatic cmd(input int op, input int ci, input int sel, input bit w,
                      input bit x, input longint p, input longint l);
      @(negedge clk);
      check_outputs();
      model_apply(op, ci, sel, w, x, p, l);
      cmd_op = 2'(op); callinc = 2'(ci); sp_sel = 4'(sel);
      woe = w; excm = x; pc = PC_W'(p); link = PC_W'(l);
   endtask

   task automatic do_reset();
      @(negedge clk);
      check_outputs();
      rst_n = 1'b0; cmd_op = 2'd0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state checked by the next step; R9 alloca fault at reset
      cmd(3, 0, 0, 1, 0, 32'h1000_0000, 0);
      // R8 underflows from reset state, one per size
      cmd(2, 0, 0, 1, 0, 32'h4000_0010, 32'h8000_0100);   // n=2 -> UNF8
      do_reset();
      cmd(2, 0, 0, 1, 0, 32'h4000_0020, 32'h4000_0200);   // n=1 -> UNF4
      do_reset();
      cmd(2, 0, 0, 1, 0, 32'h4000_0030, 32'hC000_0300);   // n=3 -> UNF12
      do_reset();
      // R3 entries build frames
      cmd(1, 1, 1, 1, 0, 32'h100, 0);
      cmd(1, 2, 2, 1, 0, 32'h104, 0);
      cmd(1, 3, 3, 1, 0, 32'h108, 0);
      cmd(0, 0, 0, 1, 0, 0, 0);                             // R10 idle
      cmd(3, 0, 0, 1, 0, 32'h10C, 0);                       // R9 passes
      // R7 legal return n=3
      cmd(2, 0, 0, 1, 0, 32'h8000_0110, 32'hC123_4560);
      // R6 illegal returns
      cmd(2, 0, 0, 1, 0, 32'h114, 32'h4000_0000);           // m=2, n=1
      cmd(2, 0, 0, 1, 0, 32'h118, 32'h0000_0000);           // n=0
      cmd(2, 0, 0, 0, 0, 32'h11C, 32'h8000_0000);           // woe clear
      // R2 illegal entries
      cmd(1, 1, 4, 1, 0, 32'h120, 0);
      cmd(1, 1, 0, 1, 1, 32'h124, 0);
      cmd(1, 1, 0, 0, 0, 32'h128, 0);
      // R4 fill until overflow
      for (int k = 0; k < 6; k++) cmd(1, 3, 1, 1, 0, 32'h200 + 4 * k, 0);
      do_reset();
      cmd(1, 3, 1, 1, 0, 32'h300, 0);
      cmd(1, 2, 1, 1, 0, 32'h304, 0);
      for (int k = 0; k < 8; k++) cmd(1, 3, 1, 1, 0, 32'h308 + 4 * k, 0);

      // random mix, R2..R10 under varied patterns
      for (int r = 0; r < 600; r++) begin
         int op  = int'($urandom_range(0, 3));
         int ci  = int'($urandom_range(0, 3));
         int sel = ($urandom_range(0, 9) == 0) ? 5 : int'($urandom_range(0, 3));
         bit w   = ($urandom_range(0, 9) != 0);
         bit x   = ($urandom_range(0, 9) == 0);
         longint p = longint'($urandom);
         longint l = longint'($urandom);
         if (r % 97 == 96) do_reset();
         cmd(op, ci, sel, w, x, p, l);
      end
      cmd(0, 0, 0, 1, 0, 0, 0);
      @(negedge clk);
      check_outputs();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule